// File: doc/BRIEF.md
# Multiplexed External Bus Interface

This block sits between a 16-bit processor core and off-chip memory that shares one set of pins for address and data. The core hands it a request (address, write data, direction, byte or word size, and a flag that marks the target as on-chip), and the block runs one or two external bus cycles. Each cycle has an address phase, where the latch-enable strobe is high and the lanes carry the address. It then has a data phase, where the active-low enable strobe is low and the lanes carry data. An external wait input can stretch the data phase.

Two 8-bit lanes carry the multiplexed traffic. A width-select input picks between a 16-bit external bus and an 8-bit external bus. On the 16-bit bus, the lower lane holds even bytes and the upper lane holds odd bytes. On the 8-bit bus, the upper lane keeps presenting address bits while the lower lane moves one byte per cycle, so a word takes two back-to-back cycles. A bus-grant handshake lets an external master take the bus while the block is idle, and the block floats its pins in steps around the acknowledge. A separate divided clock output keeps running while wait states are being inserted.

Top module: `mxbus_biu`

## Requirements
- R1: While reset is held low, and in the first cycle after it, ale_o=0, e_n_o=1, hlda_n_o=1, bus_oe_o=1, req_ready_o=1 and rsp_valid_o=0.
- R2: Each external cycle is one address-phase clock with ale_o=1 and e_n_o=1, then a data phase with ale_o=0. During the address phase the address is presented as {addr_hi_o, hi_o, lo_o}. ale_o and a low e_n_o are never active together.
- R3: rw_o is 1 for a read and 0 for a write. bhe_n_o is 0 exactly when the odd byte moves in the current cycle. A word on the 16-bit bus shows address bit 0 = 0 with bhe_n_o = 0.
- R4: With bus8_i=0, the even byte moves on the lower lane and the odd byte moves on the upper lane. A word access is one cycle and must use an even address; bit 0 of a word address is ignored.
- R5: With bus8_i=1, the upper lane stays driven with address bits 15:8 for the whole data phase. A word access runs as two cycles, even byte first and then odd byte at address|1, and each cycle has its own ale_o pulse and its own e_n_o low phase.
- R6: A read with req_int_i=1 returns zero data whatever the lanes carry. When strobe_mask_i=1, an access with req_int_i=1 never drives e_n_o low, so no external write takes place.
- R7: rdy_i low at the end of a data-phase clock repeats the data phase. A data phase with N low samples lasts N+1 clocks, and read data is taken on the clock where rdy_i is high.
- R8: hold_req_i is taken only when no bus cycle is in progress. hlda_n_o goes low in the clock after it is sampled, and it stays low until the request is withdrawn.
- R9: bus_oe_o drops one clock after hlda_n_o falls. After hold_req_i is withdrawn, hlda_n_o rises first and bus_oe_o returns one clock later.
- R10: req_ready_o is low while a cycle runs, while a hold request is pending and while the bus is granted. A request held across those periods is accepted afterwards and is not lost.
- R11: With clkout_en_i=1, phi1_o toggles on every clock, including clocks where rdy_i is low. With clkout_en_i=0 it is held at 0.
- R12: rsp_valid_o pulses for one clock, in the clock after the last data phase. Read data is lane-positioned: the even byte is in bits 7:0, the odd byte is in bits 15:8, and a byte that was not read is 0. A write returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Request accepted on this clock when high |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 16 | Write data, lane-positioned |
| req_we_i | input | 1 | 1 = write |
| req_word_i | input | 1 | 1 = 16-bit access |
| req_int_i | input | 1 | Target is on-chip memory |
| rsp_valid_o | output | 1 | Access finished |
| rsp_rdata_o | output | 16 | Read data, lane-positioned |
| bus8_i | input | 1 | 1 = 8-bit external bus |
| strobe_mask_i | input | 1 | Keep e_n_o high on on-chip accesses |
| clkout_en_i | input | 1 | Enable phi1_o |
| rdy_i | input | 1 | External ready; low inserts wait clocks |
| hold_req_i | input | 1 | External bus request |
| hlda_n_o | output | 1 | Bus grant acknowledge, active low |
| addr_hi_o | output | ADDR_W-16 | Non-multiplexed upper address |
| lo_o | output | 8 | Lower lane output value |
| lo_oe_o | output | 1 | Lower lane drive enable |
| lo_i | input | 8 | Lower lane input value |
| hi_o | output | 8 | Upper lane output value |
| hi_oe_o | output | 1 | Upper lane drive enable |
| hi_i | input | 8 | Upper lane input value |
| rw_o | output | 1 | 1 = read, 0 = write |
| bhe_n_o | output | 1 | Odd byte enable, active low |
| ale_o | output | 1 | Address latch enable |
| e_n_o | output | 1 | Data strobe, active low |
| bus_oe_o | output | 1 | Drive enable for address, rw_o and bhe_n_o |
| phi1_o | output | 1 | Free-running divided clock |

## Verification
The assertions check, on every clock, that the latch strobe and the data strobe never overlap, that a low ready keeps the data strobe low into the next clock, and that a grant follows only a pending request with no cycle running. They also check that the float and re-drive steps lag the acknowledge edges by exactly one clock, that no request is accepted while the bus is granted, and that phi1_o keeps toggling. Lane placement, the two-cycle split on the narrow bus, the ignoring of lane data for on-chip reads, data-phase lengths under waits and the return of stalled requests depend on a memory model and on the data contents, so only the bench scenarios show them.

// File: rtl/mxbus_pkg.sv
// Shared types for the multiplexed bus interface.
package mxbus_pkg;
    // Sequencer states: bus cycle phases and bus-grant steps.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR,
        ST_DAT,
        ST_GRANT,
        ST_FLOAT,
        ST_RELEASE
    } bus_st_t;

    // Attributes of the access in flight, latched at acceptance.
    typedef struct packed {
        logic we;
        logic word;
        logic internal;
        logic narrow;
        logic mask;
    } req_attr_t;
endpackage

// File: rtl/mxbus_seq.sv
// Bus sequencer. Accepts one core request at a time, steps the address and
// data phases, splits narrow-bus words into two beats, stretches on a low
// ready and walks the bus-grant handshake.
// Assumes the core holds a request stable until req_ready_o is seen high.
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_we_i,
    input  logic              req_word_i,
    input  logic              req_int_i,
    input  logic              bus8_i,
    input  logic              strobe_mask_i,
    input  logic              rdy_i,
    input  logic              hold_req_i,
    output bus_st_t           state_o,
    output req_attr_t         attr_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              cur_odd_o,
    output logic              accept_o,
    output logic              beat_done_o,
    output logic              req_ready_o,
    output logic              rsp_valid_o
);
    bus_st_t           state_q;
    req_attr_t         attr_q;
    logic [ADDR_W-1:1] addr_q;
    logic              odd_q;
    logic              rsp_q;

    // Handshake and beat-completion decode.
    always_comb begin
        req_ready_o = (state_q == ST_IDLE) && !hold_req_i;
        accept_o    = req_ready_o && req_i;
        beat_done_o = (state_q == ST_DAT) && rdy_i;
    end

    // State, request latch and beat tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            attr_q  <= '0;
            addr_q  <= '0;
            odd_q   <= 1'b0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (hold_req_i) begin
                        state_q <= ST_GRANT;
                    end else if (req_i) begin
                        attr_q  <= '{we: req_we_i, word: req_word_i,
                                     internal: req_int_i, narrow: bus8_i,
                                     mask: strobe_mask_i};
                        addr_q  <= req_addr_i[ADDR_W-1:1];
                        odd_q   <= req_word_i ? 1'b0 : req_addr_i[0];
                        state_q <= ST_ADR;
                    end
                end
                ST_ADR: state_q <= ST_DAT;
                ST_DAT: begin
                    if (rdy_i) begin
                        if (attr_q.narrow && attr_q.word && !odd_q) begin
                            odd_q   <= 1'b1;
                            state_q <= ST_ADR;
                        end else begin
                            rsp_q   <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_GRANT:   state_q <= ST_FLOAT;
                ST_FLOAT:   if (!hold_req_i) state_q <= ST_RELEASE;
                ST_RELEASE: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o     = state_q;
    assign attr_o      = attr_q;
    assign bus_addr_o  = {addr_q, odd_q};
    assign cur_odd_o   = odd_q;
    assign rsp_valid_o = rsp_q;
endmodule

// File: rtl/mxbus_pins.sv
// Pin stage. Derives strobes, lane values and drive enables from the
// sequencer state, holds write data, and gathers read data by lane.
// Assumes the lane inputs are stable at the clock edge that ends a data beat.
module mxbus_pins
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  bus_st_t                  state_i,
    input  req_attr_t                attr_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic                     cur_odd_i,
    input  logic                     accept_i,
    input  logic                     beat_done_i,
    input  logic [2*LANE_W-1:0]      wdata_i,
    input  logic [LANE_W-1:0]        lo_i,
    input  logic [LANE_W-1:0]        hi_i,
    output logic [ADDR_W-2*LANE_W-1:0] addr_hi_o,
    output logic [LANE_W-1:0]        lo_o,
    output logic                     lo_oe_o,
    output logic [LANE_W-1:0]        hi_o,
    output logic                     hi_oe_o,
    output logic                     rw_o,
    output logic                     bhe_n_o,
    output logic                     ale_o,
    output logic                     e_n_o,
    output logic                     bus_oe_o,
    output logic                     hlda_n_o,
    output logic [2*LANE_W-1:0]      rdata_o
);
    localparam int DATA_W = 2 * LANE_W;

    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              in_cycle;
    logic              drive;
    logic              rd_dat;
    logic              wr_dat;

    // Strobes, direction and drive enables.
    always_comb begin
        in_cycle = (state_i == ST_ADR) || (state_i == ST_DAT);
        drive    = !((state_i == ST_FLOAT) || (state_i == ST_RELEASE));
        rd_dat   = (state_i == ST_DAT) && !attr_i.we;
        wr_dat   = (state_i == ST_DAT) && attr_i.we;
        bus_oe_o = drive;
        hlda_n_o = !((state_i == ST_GRANT) || (state_i == ST_FLOAT));
        ale_o    = (state_i == ST_ADR);
        e_n_o    = !((state_i == ST_DAT) && !(attr_i.internal && attr_i.mask));
        rw_o     = !(in_cycle && attr_i.we);
        bhe_n_o  = !(in_cycle && (cur_odd_i || (attr_i.word && !attr_i.narrow)));
        lo_oe_o  = drive && !rd_dat;
        hi_oe_o  = drive && !(rd_dat && !attr_i.narrow);
    end

    // Lane values: address in the address phase, data in a write data phase.
    always_comb begin
        addr_hi_o = bus_addr_i[ADDR_W-1:DATA_W];
        lo_o      = bus_addr_i[LANE_W-1:0];
        hi_o      = bus_addr_i[DATA_W-1:LANE_W];
        if (wr_dat) begin
            if (attr_i.narrow && cur_odd_i) lo_o = wdata_q[DATA_W-1:LANE_W];
            else                            lo_o = wdata_q[LANE_W-1:0];
            if (!attr_i.narrow)             hi_o = wdata_q[DATA_W-1:LANE_W];
        end
    end

    // Write data holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)        wdata_q <= '0;
        else if (accept_i) wdata_q <= wdata_i;
    end

    // Read data gathering; on-chip reads leave the register cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept_i) begin
            rdata_q <= '0;
        end else if (beat_done_i && !attr_i.we && !attr_i.internal) begin
            if (attr_i.narrow) begin
                if (cur_odd_i) rdata_q[DATA_W-1:LANE_W] <= lo_i;
                else           rdata_q[LANE_W-1:0]      <= lo_i;
            end else begin
                if (!cur_odd_i)                rdata_q[LANE_W-1:0]      <= lo_i;
                if (cur_odd_i || attr_i.word)  rdata_q[DATA_W-1:LANE_W] <= hi_i;
            end
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/mxbus_clkout.sv
// Divided clock output. Toggles every clock while enabled, regardless of
// wait states; parked low while disabled.
module mxbus_clkout (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic phi1_o
);
    logic phi_q;

    // Toggle flop with enable.
    always_ff @(posedge clk) begin
        if (!rst_n)    phi_q <= 1'b0;
        else if (en_i) phi_q <= !phi_q;
        else           phi_q <= 1'b0;
    end

    assign phi1_o = phi_q;
endmodule

// File: rtl/mxbus_biu.sv
// Multiplexed external bus interface, top level. Connects the sequencer,
// the pin stage and the clock output. Lane width is LANE_W; the core data
// word is two lanes wide and ADDR_W must exceed two lanes.
module mxbus_biu
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    output logic                         req_ready_o,
    input  logic [ADDR_W-1:0]            req_addr_i,
    input  logic [2*LANE_W-1:0]          req_wdata_i,
    input  logic                         req_we_i,
    input  logic                         req_word_i,
    input  logic                         req_int_i,
    output logic                         rsp_valid_o,
    output logic [2*LANE_W-1:0]          rsp_rdata_o,
    input  logic                         bus8_i,
    input  logic                         strobe_mask_i,
    input  logic                         clkout_en_i,
    input  logic                         rdy_i,
    input  logic                         hold_req_i,
    output logic                         hlda_n_o,
    output logic [ADDR_W-2*LANE_W-1:0]   addr_hi_o,
    output logic [LANE_W-1:0]            lo_o,
    output logic                         lo_oe_o,
    input  logic [LANE_W-1:0]            lo_i,
    output logic [LANE_W-1:0]            hi_o,
    output logic                         hi_oe_o,
    input  logic [LANE_W-1:0]            hi_i,
    output logic                         rw_o,
    output logic                         bhe_n_o,
    output logic                         ale_o,
    output logic                         e_n_o,
    output logic                         bus_oe_o,
    output logic                         phi1_o
);
    bus_st_t           state;
    req_attr_t         attr;
    logic [ADDR_W-1:0] bus_addr;
    logic              cur_odd;
    logic              accept;
    logic              beat_done;

    mxbus_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .req_addr_i    (req_addr_i),
        .req_we_i      (req_we_i),
        .req_word_i    (req_word_i),
        .req_int_i     (req_int_i),
        .bus8_i        (bus8_i),
        .strobe_mask_i (strobe_mask_i),
        .rdy_i         (rdy_i),
        .hold_req_i    (hold_req_i),
        .state_o       (state),
        .attr_o        (attr),
        .bus_addr_o    (bus_addr),
        .cur_odd_o     (cur_odd),
        .accept_o      (accept),
        .beat_done_o   (beat_done),
        .req_ready_o   (req_ready_o),
        .rsp_valid_o   (rsp_valid_o)
    );

    mxbus_pins #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .attr_i      (attr),
        .bus_addr_i  (bus_addr),
        .cur_odd_i   (cur_odd),
        .accept_i    (accept),
        .beat_done_i (beat_done),
        .wdata_i     (req_wdata_i),
        .lo_i        (lo_i),
        .hi_i        (hi_i),
        .addr_hi_o   (addr_hi_o),
        .lo_o        (lo_o),
        .lo_oe_o     (lo_oe_o),
        .hi_o        (hi_o),
        .hi_oe_o     (hi_oe_o),
        .rw_o        (rw_o),
        .bhe_n_o     (bhe_n_o),
        .ale_o       (ale_o),
        .e_n_o       (e_n_o),
        .bus_oe_o    (bus_oe_o),
        .hlda_n_o    (hlda_n_o),
        .rdata_o     (rsp_rdata_o)
    );

    mxbus_clkout u_clkout (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (clkout_en_i),
        .phi1_o (phi1_o)
    );
endmodule

// File: rtl/mxbus_biu_chk.sv
// Port-level protocol checker for mxbus_biu, attached by bind.
module mxbus_biu_chk (
    input logic clk,
    input logic rst_n,
    input logic ale_o,
    input logic e_n_o,
    input logic rdy_i,
    input logic hlda_n_o,
    input logic hold_req_i,
    input logic bus_oe_o,
    input logic req_ready_o,
    input logic clkout_en_i,
    input logic phi1_o
);
    // R2: address strobe and data strobe never active together
    a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_o && !e_n_o));

    // R7: a low ready holds the data strobe into the next clock
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_n_o && !rdy_i) |=> !e_n_o);

    // R8: grant only after a pending request with no cycle running
    a_r8_grant_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda_n_o) |-> $past(hold_req_i && !ale_o && e_n_o));

    // R9: float one clock after the acknowledge falls
    a_r9_float_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda_n_o) |=> !bus_oe_o);

    // R9: drive again one clock after the acknowledge rises
    a_r9_redrive_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda_n_o) |=> bus_oe_o);

    // R10: no acceptance while the bus is granted
    a_r10_no_accept_granted: assert property (@(posedge clk) disable iff (!rst_n)
        !hlda_n_o |-> !req_ready_o);

    // R11: clock output toggles every clock while enabled
    a_r11_clkout_runs: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clkout_en_i) && $past(rst_n)) |-> (phi1_o != $past(phi1_o)));
endmodule

bind mxbus_biu mxbus_biu_chk u_chk (.*);

// File: tb/mxbus_biu_test.sv
module mxbus_biu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        req_ready_o;
    logic [23:0] req_addr_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic        req_we_i = 1'b0;
    logic        req_word_i = 1'b0;
    logic        req_int_i = 1'b0;
    logic        rsp_valid_o;
    logic [15:0] rsp_rdata_o;
    logic        bus8_i = 1'b0;
    logic        strobe_mask_i = 1'b0;
    logic        clkout_en_i = 1'b1;
    logic        rdy_i;
    logic        hold_req_i = 1'b0;
    logic        hlda_n_o;
    logic [7:0]  addr_hi_o;
    logic [7:0]  lo_o, hi_o, lo_i, hi_i;
    logic        lo_oe_o, hi_oe_o, rw_o, bhe_n_o, ale_o, e_n_o, bus_oe_o, phi1_o;

    always #4 clk = ~clk;

    mxbus_biu uut (.*);

    int checks = 0;
    int errs = 0;

    // external memory model and bench reference
    logic [7:0]  mem  [0:255];
    logic [7:0]  refm [0:255];
    logic [23:0] la = '0;
    int          wait_n = 0;
    int          wcnt = 0;

    assign rdy_i = (wcnt == 0);
    assign lo_i  = bus8_i ? mem[la[7:0]] : mem[{la[7:1], 1'b0}];
    assign hi_i  = bus8_i ? 8'hEE : mem[{la[7:1], 1'b1}];

    // wait counter: loaded in the address phase
    always @(posedge clk) begin
        if (ale_o)          wcnt <= wait_n;
        else if (wcnt != 0) wcnt <= wcnt - 1;
    end

    // observation counters
    int ale_cnt = 0, e_low = 0, hi_bad = 0, phi_bad = 0;
    logic        last_rw = 1'b1, last_bhe = 1'b1, prev_phi = 1'b0, prev_en = 1'b0;
    logic [23:0] last_addr = '0;

    // bus monitor and memory model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ale_o) begin
                la        <= {addr_hi_o, hi_o, lo_o};
                last_addr <= {addr_hi_o, hi_o, lo_o};
                last_rw   <= rw_o;
                last_bhe  <= bhe_n_o;
                ale_cnt   <= ale_cnt + 1;
            end
            if (!e_n_o) begin
                e_low <= e_low + 1;
                if (bus8_i && (!hi_oe_o || hi_o != la[15:8])) hi_bad <= hi_bad + 1;
                if (!rw_o && rdy_i) begin
                    if (bus8_i) mem[la[7:0]] <= lo_o;
                    else begin
                        if (!la[0])    mem[{la[7:1], 1'b0}] <= lo_o;
                        if (!bhe_n_o)  mem[{la[7:1], 1'b1}] <= hi_o;
                    end
                end
            end
            if (clkout_en_i && prev_en && phi1_o == prev_phi) phi_bad <= phi_bad + 1;
            prev_phi <= phi1_o;
            prev_en  <= clkout_en_i;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid_o) begin
            if (exp_q.size() == 0) chk(1'b0, "R12", "unexpected response", 1, 0);
            else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_rdata_o == e, t, "response data", int'(rsp_rdata_o), int'(e));
            end
        end
    end

    // driver: computes the expected result, pushes it, performs the handshake
    task automatic issue(input logic [23:0] a, input logic [15:0] wd, input bit we,
                         input bit word, input bit intl, input string tag);
        logic [15:0] e;
        logic [7:0]  ev, od, ix;
        ix = a[7:0];
        ev = {ix[7:1], 1'b0};
        od = {ix[7:1], 1'b1};
        if (we || intl)  e = 16'h0;
        else if (word)   e = {refm[od], refm[ev]};
        else if (ix[0])  e = {refm[ix], 8'h00};
        else             e = {8'h00, refm[ix]};
        if (we && (!intl || !strobe_mask_i)) begin
            if (word) begin refm[ev] = wd[7:0]; refm[od] = wd[15:8]; end
            else if (ix[0]) refm[ix] = wd[15:8];
            else            refm[ix] = wd[7:0];
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_i = 1'b1; req_addr_i = a; req_wdata_i = wd;
        req_we_i = we; req_word_i = word; req_int_i = intl;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [23:0] a, input logic [15:0] wd, input bit we,
                       input bit word, input bit intl, input string tag);
        issue(a, wd, we, word, intl, tag);
        drain();
    endtask

    int a0, e0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!ale_o && e_n_o && hlda_n_o && bus_oe_o, "R1", "strobes in reset", {ale_o, e_n_o, hlda_n_o, bus_oe_o}, 4'b0111);
        chk(req_ready_o && !rsp_valid_o, "R1", "handshake in reset", {req_ready_o, rsp_valid_o}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ale_o && e_n_o && hlda_n_o && bus_oe_o && req_ready_o && !rsp_valid_o,
            "R1", "first cycle after reset", 0, 0);

        // 16-bit bus
        a0 = ale_cnt; e0 = e_low;
        run(24'h3C0010, 16'hBEEF, 1, 1, 0, "R4");
        chk(last_addr == 24'h3C0010, "R2", "address phase value", int'(last_addr), 24'h3C0010);
        chk(!last_rw && !last_bhe, "R3", "word write rw/bhe", {last_rw, last_bhe}, 0);
        chk(ale_cnt - a0 == 1 && e_low - e0 == 1, "R4", "single cycle per word", ale_cnt - a0, 1);
        run(24'h3C0010, 16'h0, 0, 1, 0, "R4");
        chk(last_rw == 1'b1, "R3", "read rw", int'(last_rw), 1);
        run(24'h3C0021, 16'h5A00, 1, 0, 0, "R12");
        chk(!last_bhe && last_addr[0], "R3", "odd byte bhe", int'(last_bhe), 0);
        run(24'h3C0020, 16'h0, 0, 0, 0, "R12");
        chk(last_bhe == 1'b1, "R3", "even byte bhe", int'(last_bhe), 1);
        run(24'h3C0021, 16'h0, 0, 0, 0, "R4");

        // R7: wait states on the 16-bit bus
        wait_n = 3; e0 = e_low;
        run(24'h3C0010, 16'h0, 0, 1, 0, "R7");
        chk(e_low - e0 == 4, "R7", "data phase length", e_low - e0, 4);
        chk(phi_bad == 0, "R11", "clock output during waits", phi_bad, 0);
        wait_n = 0;

        // 8-bit bus
        bus8_i = 1'b1;
        a0 = ale_cnt; e0 = e_low;
        run(24'h3C0030, 16'h1234, 1, 1, 0, "R5");
        chk(ale_cnt - a0 == 2 && e_low - e0 == 2, "R5", "word split into two cycles", ale_cnt - a0, 2);
        chk(last_addr == 24'h3C0031 && !last_bhe, "R5", "second cycle odd address", int'(last_addr), 24'h3C0031);
        run(24'h3C0030, 16'h0, 0, 1, 0, "R5");
        run(24'h3C0021, 16'h0, 0, 0, 0, "R5");
        wait_n = 2; e0 = e_low;
        run(24'h3C0010, 16'h0, 0, 1, 0, "R7");
        chk(e_low - e0 == 6, "R7", "narrow data phases with waits", e_low - e0, 6);
        chk(hi_bad == 0, "R5", "upper lane keeps address", hi_bad, 0);
        wait_n = 0;
        bus8_i = 1'b0;

        // R6: on-chip accesses
        strobe_mask_i = 1'b1; e0 = e_low;
        run(24'h3C0040, 16'hFFFF, 1, 1, 1, "R6");
        run(24'h3C0010, 16'h0, 0, 1, 1, "R6");
        chk(e_low == e0, "R6", "masked strobe stays high", e_low - e0, 0);
        run(24'h3C0040, 16'h0, 0, 1, 0, "R6");
        strobe_mask_i = 1'b0; e0 = e_low;
        run(24'h3C0010, 16'h0, 0, 1, 1, "R6");
        chk(e_low - e0 == 1, "R6", "unmasked on-chip strobe", e_low - e0, 1);

        // R8/R9/R10: bus grant
        @(negedge clk);
        hold_req_i = 1'b1;
        #1;
        chk(!req_ready_o, "R10", "ready drops with hold request", int'(req_ready_o), 0);
        @(negedge clk);
        chk(!hlda_n_o && bus_oe_o, "R8", "acknowledge then still driving", {hlda_n_o, bus_oe_o}, 2'b01);
        @(negedge clk);
        chk(!hlda_n_o && !bus_oe_o, "R9", "float after acknowledge", {hlda_n_o, bus_oe_o}, 2'b00);
        fork
            issue(24'h3C0010, 16'h0, 0, 1, 0, "R10");
            begin
                repeat (5) @(negedge clk);
                chk(!req_ready_o && !hlda_n_o && !bus_oe_o, "R10", "stalled while granted", int'(req_ready_o), 0);
                hold_req_i = 1'b0;
                @(negedge clk);
                chk(hlda_n_o && !bus_oe_o, "R9", "acknowledge rises before redrive", {hlda_n_o, bus_oe_o}, 2'b10);
                @(negedge clk);
                chk(bus_oe_o, "R9", "redrive after release", int'(bus_oe_o), 1);
            end
        join
        drain();

        // R11: disabled clock output
        clkout_en_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(phi1_o == 1'b0, "R11", "disabled clock output low", int'(phi1_o), 0);
        chk(phi_bad == 0 && exp_q.size() == 0, "R11", "no missed toggles", phi_bad, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule